// File: doc/BRIEF.md
# Effective Address Load Unit

This execution unit carries out the load-effective-address operation of a segmented processor that runs with either 16-bit or 32-bit operand and address attributes. Decode hands it the opcode byte, the register/memory specifier byte and the scale/index/base byte. It also gets the register values that those bytes name, the displacement and the two size attributes. The unit forms the offset part of the address and returns it as a register write. It does not touch memory, add a segment base, check a limit or change a flag.

The two attributes are independent of each other. A 32-bit offset can be cut down to a 16-bit register, and a 16-bit offset can be zero-extended into a 32-bit register. When the specifier names a register instead of memory, the unit raises an invalid-opcode exception and writes nothing. Inputs arrive through a valid/ready handshake, and one operation can be accepted every cycle. Each accepted operation produces exactly one result strobe two clocks later.

Top module: `ea_load_unit`

## Requirements
- R1: While `rst_n` is low, `in_ready`, `wr_en` and `exc_valid` are 0. One clock after reset is released, `in_ready` is 1.
- R2: With 16-bit addressing, the offset is formed from `rm` = `spec[2:0]` and `mod` = `spec[7:6]`. The terms are: rm 0 base+index, 1 base+index, 2 base+index, 3 base+index, 4 index, 5 index, 6 base, 7 base. Here `base_val` holds BX or BP and `index_val` holds SI or DI. When mod=0 and rm=6, the offset is `disp[15:0]` alone. mod=2 adds `disp[15:0]`. The sum wraps modulo 2^16.
- R3: With 32-bit addressing, the offset is base + (index << scale) + displacement, modulo 2^32. `scale` = `sib[7:6]`, index code = `sib[5:3]`, base code = `sib[2:0]`. The scale/index/base byte is used only when rm=4, and index code 4 means no index. When mod=0 and rm=5, or when mod=0 with rm=4 and base code 5, there is no base and the full 32-bit `disp` is added. mod=2 adds the full `disp`.
- R4: With operand size 16 and address size 16, `wr_data` = {16'h0, 16-bit offset} and `wr_mask` = 2'b01.
- R5: With operand size 16 and address size 32, only the low 16 bits of the 32-bit offset are written: `wr_data[31:16]` = 0 and `wr_mask` = 2'b01.
- R6: With operand size 32 and address size 16, the 16-bit offset is zero-extended and `wr_mask` = 2'b11.
- R7: With operand size 32 and address size 32, the whole 32-bit offset is written and `wr_mask` = 2'b11.
- R8: When mod=3 (register operand), the unit pulses `exc_valid` with `exc_vector` = 6 and keeps `wr_en` at 0.
- R9: An opcode other than 8'h8D is handled as an invalid opcode, exactly as in R8.
- R10: An operation accepted at clock edge N sets `wr_en` (or `exc_valid`) for one cycle after edge N+2. `wr_idx` = `spec[5:3]`. Results come out in acceptance order, one per accepted operation, and never with both strobes set at once.
- R11: mod=1 adds `disp[7:0]`, sign-extended to the address width, in both addressing sizes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_opcode | input | 8 | Primary opcode byte |
| in_spec | input | 8 | Register/memory specifier byte (mod, reg, rm) |
| in_sib | input | 8 | Scale/index/base byte |
| in_base_val | input | 32 | Value of the base register |
| in_index_val | input | 32 | Value of the index register |
| in_disp | input | 32 | Displacement, low bits used for short forms |
| in_op32 | input | 1 | Operand size is 32 bits |
| in_ad32 | input | 1 | Address size is 32 bits |
| wr_en | output | 1 | Destination write strobe |
| wr_idx | output | 3 | Destination register number |
| wr_data | output | 32 | Value to write |
| wr_mask | output | 2 | Half-word lanes written (bit 0 low, bit 1 high) |
| exc_valid | output | 1 | Invalid-opcode exception strobe |
| exc_vector | output | 8 | Exception vector number |

## Verification
The pipeline can accept a new operation in the same cycle that an earlier one comes out as a trap, so an exception strobe and an acceptance overlap in time. The same overlap occurs between a register write and the acceptance of a register-form operand. The bench provokes both by streaming operations back to back, with register-form and foreign-opcode items mixed among valid ones. Each result is judged against a queue of expected items that records the cycle it must appear in. A trap that leaked a write, or that shifted the order of the results around it, shows up as a miscompare.

// File: rtl/ea_load_unit.sv
module ea_load_unit #(
  parameter int          AW       = 32,
  parameter logic [7:0]  LEA_OP   = 8'h8D,
  parameter logic [7:0]  UD_VEC   = 8'd6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_opcode,
  input  logic [7:0]    in_spec,
  input  logic [7:0]    in_sib,
  input  logic [AW-1:0] in_base_val,
  input  logic [AW-1:0] in_index_val,
  input  logic [AW-1:0] in_disp,
  input  logic          in_op32,
  input  logic          in_ad32,
  output logic          wr_en,
  output logic [2:0]    wr_idx,
  output logic [AW-1:0] wr_data,
  output logic [1:0]    wr_mask,
  output logic          exc_valid,
  output logic [7:0]    exc_vector
);
  localparam int HW = AW / 2;

  logic [1:0] md;
  logic [2:0] rm, ix, bs;
  logic [1:0] sc;
  assign md = in_spec[7:6];
  assign rm = in_spec[2:0];
  assign sc = in_sib[7:6];
  assign ix = in_sib[5:3];
  assign bs = in_sib[2:0];

  logic acc, trap;
  assign acc  = in_valid & in_ready;
  assign trap = (md == 2'b11) | (in_opcode != LEA_OP);

  // 16-bit addressing terms
  logic          n_use_b, n_use_i, n_d16;
  logic [HW-1:0] n_b, n_i, n_d, n_ea;
  assign n_use_b = !(rm inside {3'd4, 3'd5}) && !(rm == 3'd6 && md == 2'b00);
  assign n_use_i = (rm[2:1] != 2'b11);
  assign n_d16   = (md == 2'b10) || (md == 2'b00 && rm == 3'd6);
  assign n_b     = n_use_b ? in_base_val[HW-1:0]  : '0;
  assign n_i     = n_use_i ? in_index_val[HW-1:0] : '0;
  assign n_d     = (md == 2'b01) ? {{(HW-8){in_disp[7]}}, in_disp[7:0]} :
                   n_d16         ? in_disp[HW-1:0] : '0;
  assign n_ea    = n_b + n_i + n_d;

  // 32-bit addressing terms
  logic          w_sib, w_nobase, w_dfull, w_use_i;
  logic [AW-1:0] w_b, w_i, w_d, w_ea;
  assign w_sib    = (rm == 3'd4);
  assign w_nobase = (md == 2'b00) && ((rm == 3'd5) || (w_sib && bs == 3'd5));
  assign w_dfull  = (md == 2'b10) || w_nobase;
  assign w_use_i  = w_sib && (ix != 3'd4);
  assign w_b      = w_nobase ? '0 : in_base_val;
  assign w_i      = w_use_i ? (in_index_val << sc) : '0;
  assign w_d      = (md == 2'b01) ? {{(AW-8){in_disp[7]}}, in_disp[7:0]} :
                    w_dfull       ? in_disp : '0;
  assign w_ea     = w_b + w_i + w_d;

  // stage 1: offset registered at acceptance
  logic          s1_v, s1_ud, s1_op32, s1_ad32;
  logic [2:0]    s1_dst;
  logic [AW-1:0] s1_ea;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      s1_v     <= 1'b0;
      s1_ud    <= 1'b0;
      s1_op32  <= 1'b0;
      s1_ad32  <= 1'b0;
      s1_dst   <= '0;
      s1_ea    <= '0;
    end else begin
      in_ready <= 1'b1;
      s1_v     <= acc;
      s1_ud    <= acc & trap;
      s1_op32  <= in_op32;
      s1_ad32  <= in_ad32;
      s1_dst   <= in_spec[5:3];
      s1_ea    <= in_ad32 ? w_ea : {{(AW-HW){1'b0}}, n_ea};
    end
  end

  // stage 2: size the result and drive the write port
  logic [AW-1:0] sized;
  assign sized = (s1_op32 && s1_ad32) ? s1_ea : {{(AW-HW){1'b0}}, s1_ea[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      wr_mask    <= '0;
      exc_valid  <= 1'b0;
      exc_vector <= '0;
    end else begin
      wr_en      <= s1_v & ~s1_ud;
      wr_idx     <= s1_dst;
      wr_data    <= (s1_v & ~s1_ud) ? sized : '0;
      wr_mask    <= (s1_v & ~s1_ud) ? (s1_op32 ? 2'b11 : 2'b01) : 2'b00;
      exc_valid  <= s1_v & s1_ud;
      exc_vector <= (s1_v & s1_ud) ? UD_VEC : 8'd0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !wr_en && !exc_valid && !in_ready); // R1
  AST_REGFORM_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc && in_spec[7:6] == 2'b11, 2) |-> exc_valid && !wr_en && exc_vector == UD_VEC); // R8
  AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || exc_valid) |-> $past(acc, 2)); // R10
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && exc_valid)); // R10
  AST_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_mask == ($past(in_op32, 2) ? 2'b11 : 2'b01)); // R6
  AST_SHORT_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(in_ad32, 2)) |-> wr_data[AW-1:HW] == '0); // R4
  AST_NARROW_DEST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(in_op32, 2)) |-> wr_data[AW-1:HW] == '0); // R5
endmodule

// File: tb/test_ea_load_unit.sv
`timescale 1ns/1ps
module test_ea_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0, in_spec = '0, in_sib = '0;
  logic [31:0] in_base_val = '0, in_index_val = '0, in_disp = '0;
  logic        in_op32 = 1'b0, in_ad32 = 1'b0;
  logic        wr_en, exc_valid;
  logic [2:0]  wr_idx;
  logic [31:0] wr_data;
  logic [1:0]  wr_mask;
  logic [7:0]  exc_vector;

  always #2 clk = ~clk;

  ea_load_unit i_ea_load_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_spec(in_spec), .in_sib(in_sib),
    .in_base_val(in_base_val), .in_index_val(in_index_val), .in_disp(in_disp),
    .in_op32(in_op32), .in_ad32(in_ad32),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
    .exc_valid(exc_valid), .exc_vector(exc_vector)
  );

  typedef struct {
    int          cyc;
    logic        trap;
    logic [2:0]  idx;
    logic [31:0] data;
    logic [1:0]  mask;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cnt = 0;
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 0;

  always @(posedge clk) cnt <= cnt + 1;

  function automatic logic [31:0] offset_of(logic [7:0] spec, logic [7:0] sib,
      logic [31:0] b, logic [31:0] x, logic [31:0] d, logic ad32);
    logic [1:0]  m;
    logic [2:0]  r;
    logic [31:0] s8;
    logic [31:0] acc;
    m  = spec[7:6];
    r  = spec[2:0];
    s8 = {{24{d[7]}}, d[7:0]};
    if (!ad32) begin
      logic [15:0] t;
      case (r)
        3'd0, 3'd1, 3'd2, 3'd3: t = b[15:0] + x[15:0];
        3'd4, 3'd5:             t = x[15:0];
        3'd6:                   t = (m == 2'b00) ? 16'h0 : b[15:0];
        default:                t = b[15:0];
      endcase
      if (m == 2'b01) t = t + s8[15:0];
      else if (m == 2'b10 || (m == 2'b00 && r == 3'd6)) t = t + d[15:0];
      return {16'h0, t};
    end
    acc = 32'h0;
    if (r == 3'd4) begin
      if (sib[5:3] != 3'd4) acc = x << sib[7:6];
      if (m == 2'b00 && sib[2:0] == 3'd5) acc = acc + d;
      else acc = acc + b;
    end else if (m == 2'b00 && r == 3'd5) begin
      acc = d;
    end else begin
      acc = b;
    end
    if (m == 2'b01) acc = acc + s8;
    else if (m == 2'b10) acc = acc + d;
    return acc;
  endfunction

  task automatic drive(logic [7:0] op, logic [7:0] spec, logic [7:0] sib,
      logic [31:0] b, logic [31:0] x, logic [31:0] d, logic op32, logic ad32, string atag);
    exp_t e;
    logic [31:0] off;
    in_valid = 1'b1; in_opcode = op; in_spec = spec; in_sib = sib;
    in_base_val = b; in_index_val = x; in_disp = d; in_op32 = op32; in_ad32 = ad32;
    e.cyc  = cnt + 2;
    e.idx  = spec[5:3];
    e.trap = (spec[7:6] == 2'b11) || (op != 8'h8D);
    off    = offset_of(spec, sib, b, x, d, ad32);
    e.data = (op32 && ad32) ? off : {16'h0, off[15:0]};
    e.mask = op32 ? 2'b11 : 2'b01;
    if (op != 8'h8D) e.tag = "R9";
    else if (e.trap) e.tag = "R8";
    else if (!op32 && !ad32) e.tag = {"R4/R2", atag};
    else if (!op32 &&  ad32) e.tag = {"R5/R3", atag};
    else if ( op32 && !ad32) e.tag = {"R6/R2", atag};
    else                     e.tag = {"R7/R3", atag};
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q.size() != 0 && q[0].cyc < cnt) begin
        chk(0, "R10", "result missing at cycle", cnt, q[0].cyc);
        void'(q.pop_front());
      end
      if (wr_en || exc_valid) begin
        if (q.size() == 0) begin
          chk(0, "R10", "unexpected strobe", {30'h0, wr_en, exc_valid}, 32'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.cyc == cnt, "R10", "result cycle", cnt, e.cyc);
          chk(!(wr_en && exc_valid), "R10", "both strobes", {30'h0, wr_en, exc_valid}, 32'h0);
          if (e.trap) begin
            chk(exc_valid && !wr_en, e.tag, "trap without write", {30'h0, wr_en, exc_valid}, 32'h1);
            chk(exc_vector == 8'd6, e.tag, "vector", {24'h0, exc_vector}, 32'd6);
          end else begin
            chk(wr_en && !exc_valid, e.tag, "write strobe", {30'h0, wr_en, exc_valid}, 32'h2);
            chk(wr_idx == e.idx, "R10", "dest index", {29'h0, wr_idx}, {29'h0, e.idx});
            chk(wr_data == e.data, e.tag, "write data", wr_data, e.data);
            chk(wr_mask == e.mask, e.tag, "lane mask", {30'h0, wr_mask}, {30'h0, e.mask});
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cnt);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !exc_valid && !in_ready, "R1", "reset outputs",
        {29'h0, in_ready, wr_en, exc_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", {31'h0, in_ready}, 32'h1);

    // R2: 16-bit forms with wraparound, disp16-only, short displacement (R11)
    drive(8'h8D, 8'b01_000_000, 8'h00, 32'h0000FFF0, 32'h00000020, 32'h00000080, 0, 0, " R11");
    drive(8'h8D, 8'b00_001_110, 8'h00, 32'h12345678, 32'h0, 32'h0000ABCD, 0, 0, " disp16");
    drive(8'h8D, 8'b10_010_011, 8'h00, 32'hFFFF8000, 32'h00009000, 32'h00007FFF, 1, 0, " wrap");
    drive(8'h8D, 8'b01_011_110, 8'h00, 32'h00001000, 32'h0, 32'h0000007F, 1, 0, " R11");
    // R3: 32-bit forms: scaled index, no-index, disp32 only, no-base SIB
    drive(8'h8D, 8'b10_100_100, 8'b11_001_000, 32'hF0000000, 32'h20000001, 32'h00000010, 1, 1, " scale3");
    drive(8'h8D, 8'b01_101_100, 8'b10_100_011, 32'h00000100, 32'hDEADBEEF, 32'h000000FF, 1, 1, " noidx R11");
    drive(8'h8D, 8'b00_110_101, 8'h00, 32'hFFFFFFFF, 32'h0, 32'h89ABCDEF, 0, 1, " disp32");
    drive(8'h8D, 8'b00_111_100, 8'b01_010_101, 32'h55555555, 32'h00001000, 32'h00400000, 1, 1, " nobase");
    // R8 and R9 back to back with writes around them
    drive(8'h8D, 8'b11_000_001, 8'h00, 32'h1, 32'h2, 32'h3, 1, 1, "");
    drive(8'h8D, 8'b10_001_111, 8'h00, 32'h00010000, 32'h0, 32'h0000FFFF, 0, 0, "");
    drive(8'h8B, 8'b00_010_111, 8'h00, 32'h1, 32'h0, 32'h0, 1, 1, "");
    drive(8'h8D, 8'b11_011_000, 8'h00, 32'h1, 32'h2, 32'h3, 0, 0, "");
    idle(4);

    for (int n = 0; n < 1500; n++) begin
      logic [7:0] op, spec;
      logic [1:0] m;
      int r;
      r  = $urandom % 10;
      m  = (r == 0) ? 2'b11 : 2'(r % 3);
      op = (($urandom % 16) == 0) ? 8'($urandom) : 8'h8D;
      spec = {m, 3'($urandom), 3'($urandom)};
      drive(op, spec, 8'($urandom), $urandom, $urandom, $urandom,
            1'($urandom), 1'($urandom), " random");
      if (($urandom % 8) == 0) idle(1 + $urandom % 3);
    end
    idle(5);
    chk(q.size() == 0, "R10", "pending results at end", q.size(), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule